// File: doc/BRIEF.md
# Uplink Word Sequencer

This block produces the modulator drive of a passive read/write tag while the tag talks back to a reader. All timing is counted in carrier clocks. It walks through a configured window of 32-bit memory words. In front of each word it sends a listen-window pattern, which is the slot in which the reader may interrupt. Each word goes out as a 45-bit block that carries even parity per byte and per column, and every bit is Manchester coded on `mod_on`.

On request it sends acknowledge and no-acknowledge status patterns between words. These patterns have fixed shapes that cannot be mistaken for data. A one-cycle strobe marks the long modulated segment of every listen window, so that an external receive detector knows where to sample. An abort input ends a listen window at once and leaves the modulator parked off until the next reset.

Top module: `uplink_seq`

## Requirements
- R1: Starting at `first_addr`, words are sent at addresses first, first+1, … up to `last_addr`, and the sequence then wraps back to `first_addr`. The addresses 32 and 33 (identity words) are valid members of a range.
- R2: When `first_addr` equals `last_addr`, that single word is sent over and over.
- R3: One listen window comes before every word, except the word at `first_addr`, which has two listen windows back to back in front of it.
- R4: A word frame is 45 bits sent in index order 0..44. Index 9r+j (r=0..3, j=0..7) carries data bit 8r+j. Index 9r+8 is the even parity of data byte r. Index 36+i is the XOR of data bits i, 8+i, 16+i and 24+i. Index 44 is 0.
- R5: When `rd_protect` is high for the addressed word and `login_ok` is low, all 45 frame bits are 0. With `login_ok` high, the real frame is sent.
- R6: A bit lasts 64 clocks when `half_rate`=0 and 32 clocks when it is 1. A 1 drives `mod_on` high for the first half and low for the second half. A 0 does the opposite.
- R7: A listen window is a run of segments lasting 2,2,8,4,4 units. `mod_on` is high in segments 0, 2 and 4 and low in the others. `liw_active` is high throughout the window.
- R8: A pending request sends a status pattern right after the current word and before the next listen window. The acknowledge pattern (`ack_req`) is 2,2,6,2,6,2 units. The no-acknowledge pattern (`nak_req`, which wins if both are pending) is 2,2,6,2,4,2,2 units. `mod_on` is high in the even-numbered segments, and `liw_active` stays low.
- R9: A unit is 16 clocks, or 8 when `half_rate`=1. One listen window plus one word takes 3200 clocks, or 1600 when `half_rate`=1.
- R10: If `first_addr` > `last_addr`, or if `last_addr` > 33, the range is invalid and the word at `first_addr` is sent repeatedly.
- R11: `liw_sample` pulses for exactly one cycle, in the first cycle of segment 2 of each listen window.
- R12: An `abort` seen during a listen window drops `mod_on` and `liw_active` on the next cycle, and both stay low until reset.
- R13: While `rst` is high, `mod_on`, `liw_active` and `liw_sample` are low. After release, the sequence restarts with the double listen window in front of `first_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst | input | 1 | Synchronous active-high reset |
| first_addr | input | 6 | First word of the output range |
| last_addr | input | 6 | Last word of the output range |
| half_rate | input | 1 | 1 selects 32 clocks per bit, 0 selects 64 |
| mem_data | input | 32 | Read data for the word at `mem_addr`, same cycle |
| rd_protect | input | 1 | Addressed word is read protected |
| login_ok | input | 1 | A valid login is active |
| ack_req | input | 1 | Pulse that requests an acknowledge pattern |
| nak_req | input | 1 | Pulse that requests a no-acknowledge pattern |
| abort | input | 1 | Stop the current listen window and park |
| mem_addr | output | 6 | Address of the word being sent or next to be sent |
| mod_on | output | 1 | Modulator enable |
| liw_active | output | 1 | High during a listen window |
| liw_sample | output | 1 | One-cycle strobe at the long modulated segment |

## Verification
The hardest case to reach is a status request that lands in the middle of a word. It has to change the gap between two words without disturbing the frame that is being sent. If the request arrives while the block is already wrapping toward the first address, it also has to keep the double listen window.

The bench pulses `ack_req` and `nak_req` in the first cycle of chosen words. It then compares `mod_on` cycle by cycle against a waveform it builds itself, segment by segment, for the word, the status pattern and the listen windows that follow. Protected words and aborts are reached by driving a per-address protect mask and by raising `abort` part way into a listen window.

// File: rtl/uplink_seq_pkg.sv
package uplink_seq_pkg;

    localparam int FRAME_BITS = 45;

    typedef enum logic [1:0] {PAT_LIW, PAT_ACK, PAT_NAK} pat_kind_e;

    typedef enum logic [2:0] {
        ST_BOOT, ST_LIW1, ST_LIW2, ST_WORD, ST_STAT, ST_PARK
    } seq_state_e;

    // 45-bit frame, index 0 goes out first
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [31:0] d);
        logic [FRAME_BITS-1:0] f;
        f = '0;
        for (int r = 0; r < 4; r++) begin
            f[r*9 +: 8] = d[r*8 +: 8];
            f[r*9 + 8]  = ^d[r*8 +: 8];
        end
        for (int i = 0; i < 8; i++) begin
            f[36 + i] = d[i] ^ d[8 + i] ^ d[16 + i] ^ d[24 + i];
        end
        f[FRAME_BITS-1] = 1'b0;
        return f;
    endfunction

    // segment length in units (unit = quarter of a full-rate bit)
    function automatic int seg_units(input pat_kind_e k, input logic [2:0] idx);
        int u;
        u = 2;
        case (k)
            PAT_LIW: case (idx)
                3'd2:       u = 8;
                3'd3, 3'd4: u = 4;
                default:    u = 2;
            endcase
            PAT_ACK: case (idx)
                3'd2, 3'd4: u = 6;
                default:    u = 2;
            endcase
            default: case (idx)
                3'd2:    u = 6;
                3'd4:    u = 4;
                default: u = 2;
            endcase
        endcase
        return u;
    endfunction

    function automatic int seg_total(input pat_kind_e k);
        case (k)
            PAT_LIW: return 5;
            PAT_ACK: return 6;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/uplink_seq_pattern.sv
module uplink_seq_pattern
    import uplink_seq_pkg::*;
#(
    parameter int BIT_CLKS = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      half,
    input  logic      start,
    input  pat_kind_e kind_i,
    input  logic      stop,
    output logic      mod,
    output logic      active_o,
    output logic      is_liw,
    output logic      long_start,
    output logic      last
);
    localparam int CW = $clog2(2*BIT_CLKS + 1);
    localparam int QF = BIT_CLKS / 4;
    localparam int QH = BIT_CLKS / 8;

    logic          active;
    pat_kind_e     kind;
    logic [2:0]    seg;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len;
    logic          seg_end, final_seg;

    always_comb begin
        len       = half ? CW'(seg_units(kind, seg) * QH) : CW'(seg_units(kind, seg) * QF);
        seg_end   = (cnt == len - CW'(1));
        final_seg = (seg == 3'(seg_total(kind) - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            kind   <= PAT_LIW;
            seg    <= '0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            kind   <= kind_i;
            seg    <= '0;
            cnt    <= '0;
        end else if (stop) begin
            active <= 1'b0;
        end else if (active) begin
            if (seg_end) begin
                cnt <= '0;
                if (final_seg) active <= 1'b0;
                else           seg    <= seg + 3'd1;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign mod        = active & ~seg[0];
    assign active_o   = active;
    assign is_liw     = active & (kind == PAT_LIW);
    assign long_start = is_liw & (seg == 3'd2) & (cnt == '0);
    assign last       = active & seg_end & final_seg;

    // R8: a finished pattern with no restart leaves the generator idle
    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        (last && !start) |=> !active);
    // R11: the sample strobe only falls inside a modulated window segment
    a_r11_strobe_modulated: assert property (@(posedge clk) disable iff (rst)
        long_start |=> (active && seg == 3'd2 && $past(mod)));

endmodule

// File: rtl/uplink_seq_wordtx.sv
module uplink_seq_wordtx
    import uplink_seq_pkg::*;
#(
    parameter int BIT_CLKS = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  half,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  mod,
    output logic                  active_o,
    output logic                  last
);
    localparam int CB = $clog2(BIT_CLKS + 1);
    localparam int NB = $clog2(FRAME_BITS + 1);

    logic                  active;
    logic [FRAME_BITS-1:0] sh;
    logic [NB-1:0]         bitn;
    logic [CB-1:0]         cyc;
    logic [CB-1:0]         per, halfp;
    logic                  bit_end;

    always_comb begin
        per     = half ? CB'(BIT_CLKS/2) : CB'(BIT_CLKS);
        halfp   = per >> 1;
        bit_end = (cyc == per - CB'(1));
    end

    assign last = active & bit_end & (bitn == NB'(FRAME_BITS-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '0;
            bitn   <= '0;
            cyc    <= '0;
        end else if (start) begin
            active <= 1'b1;
            sh     <= frame;
            bitn   <= '0;
            cyc    <= '0;
        end else if (active) begin
            if (bit_end) begin
                cyc  <= '0;
                sh   <= {1'b0, sh[FRAME_BITS-1:1]};
                bitn <= bitn + NB'(1);
                if (last) active <= 1'b0;
            end else begin
                cyc <= cyc + CB'(1);
            end
        end
    end

    assign mod      = active & ((cyc < halfp) ? sh[0] : ~sh[0]);
    assign active_o = active;

    // R4: never more than 45 bits per frame
    a_r4_bit_index: assert property (@(posedge clk) disable iff (rst)
        active |-> (bitn < NB'(FRAME_BITS)));

endmodule

// File: rtl/uplink_seq.sv
module uplink_seq
    import uplink_seq_pkg::*;
#(
    parameter int BIT_CLKS = 64,
    parameter int ADDR_W   = 6,
    parameter int LAST_ID  = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              half_rate,
    input  logic [31:0]       mem_data,
    input  logic              rd_protect,
    input  logic              login_ok,
    input  logic              ack_req,
    input  logic              nak_req,
    input  logic              abort,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mod_on,
    output logic              liw_active,
    output logic              liw_sample
);
    seq_state_e        state, nstate;
    logic [ADDR_W-1:0] cur, ncur, nxt;
    logic              pend, pend_nak, range_ok;

    logic              p_start, p_stop, p_mod, p_active, p_last;
    pat_kind_e         p_kind;
    logic              t_start, t_mod, t_active, t_last;
    logic [FRAME_BITS-1:0] t_frame;

    assign range_ok = (first_addr <= last_addr) && (last_addr <= ADDR_W'(LAST_ID));
    assign nxt      = (!range_ok || cur >= last_addr) ? first_addr : cur + ADDR_W'(1);
    assign t_frame  = (rd_protect && !login_ok) ? '0 : build_frame(mem_data);

    always_comb begin
        nstate  = state;
        ncur    = cur;
        p_start = 1'b0;
        p_stop  = 1'b0;
        p_kind  = PAT_LIW;
        t_start = 1'b0;
        case (state)
            ST_BOOT: begin
                p_start = 1'b1;
                nstate  = ST_LIW1;
            end
            ST_LIW1, ST_LIW2: begin
                if (abort) begin
                    p_stop = 1'b1;
                    nstate = ST_PARK;
                end else if (p_last) begin
                    if (state == ST_LIW1) begin
                        p_start = 1'b1;
                        nstate  = ST_LIW2;
                    end else begin
                        t_start = 1'b1;
                        nstate  = ST_WORD;
                    end
                end
            end
            ST_WORD: begin
                if (t_last) begin
                    ncur    = nxt;
                    p_start = 1'b1;
                    if (pend) begin
                        p_kind = pend_nak ? PAT_NAK : PAT_ACK;
                        nstate = ST_STAT;
                    end else begin
                        nstate = (nxt == first_addr) ? ST_LIW1 : ST_LIW2;
                    end
                end
            end
            ST_STAT: begin
                if (p_last) begin
                    p_start = 1'b1;
                    nstate  = (cur == first_addr) ? ST_LIW1 : ST_LIW2;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_BOOT;
            cur      <= first_addr;
            pend     <= 1'b0;
            pend_nak <= 1'b0;
        end else begin
            state <= nstate;
            cur   <= ncur;
            if (state == ST_WORD && t_last && pend) begin
                pend     <= 1'b0;
                pend_nak <= 1'b0;
            end
            if (ack_req || nak_req) begin
                pend <= 1'b1;
                if (nak_req) pend_nak <= 1'b1;
            end
        end
    end

    uplink_seq_pattern #(.BIT_CLKS(BIT_CLKS)) pat_i (
        .clk       (clk),
        .rst       (rst),
        .half      (half_rate),
        .start     (p_start),
        .kind_i    (p_kind),
        .stop      (p_stop),
        .mod       (p_mod),
        .active_o  (p_active),
        .is_liw    (liw_active),
        .long_start(liw_sample),
        .last      (p_last)
    );

    uplink_seq_wordtx #(.BIT_CLKS(BIT_CLKS)) tx_i (
        .clk     (clk),
        .rst     (rst),
        .half    (half_rate),
        .start   (t_start),
        .frame   (t_frame),
        .mod     (t_mod),
        .active_o(t_active),
        .last    (t_last)
    );

    assign mod_on   = p_mod | t_mod;
    assign mem_addr = cur;

    // R12: parked means silent
    a_r12_park_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARK) |-> (!mod_on && !liw_active));
    // R9: the pattern generator and word shifter never drive together
    a_r9_one_source: assert property (@(posedge clk) disable iff (rst)
        $onehot0({p_active, t_active}));
    // R1: the addressed word stays inside a valid range
    a_r1_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        (range_ok && $stable(first_addr) && $stable(last_addr))
            |-> (cur >= first_addr && cur <= last_addr));
    // R3: a word always begins right after a listen window ends
    a_r3_liw_before_word: assert property (@(posedge clk) disable iff (rst)
        $rose(t_active) |-> $past(liw_active));

endmodule

// File: tb/uplink_seq_tb_top.sv
`timescale 1ns/1ps
module uplink_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  first_a = 6'd0, last_a = 6'd0;
    logic        half = 1'b0, login = 1'b0;
    logic        ack_req = 1'b0, nak_req = 1'b0, abort = 1'b0;
    logic [63:0] prot_mask = '0;
    logic [5:0]  mem_addr;
    logic [31:0] mem_data;
    logic        rd_protect, mod_on, liw_active, liw_sample;

    int checks = 0, errors = 0;
    longint cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mval(input logic [5:0] a);
        return (32'(a) + 32'd1) * 32'h9E37_79B9 ^ {a, 26'h2A5_5A5A};
    endfunction
    assign mem_data   = mval(mem_addr);
    assign rd_protect = prot_mask[mem_addr];

    uplink_seq dut_i (
        .clk(clk), .rst(rst), .first_addr(first_a), .last_addr(last_a),
        .half_rate(half), .mem_data(mem_data), .rd_protect(rd_protect),
        .login_ok(login), .ack_req(ack_req), .nak_req(nak_req), .abort(abort),
        .mem_addr(mem_addr), .mod_on(mod_on), .liw_active(liw_active),
        .liw_sample(liw_sample)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic exp_seg(input bit lvl, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (mod_on !== lvl) bad++;
            @(negedge clk);
            ack_req = 1'b0;
            nak_req = 1'b0;
        end
        check(bad == 0, req, "mismatching modulator cycles", bad, 0);
    endtask

    // kind: 0 listen window, 1 acknowledge, 2 no-acknowledge
    task automatic exp_pat(input int kind);
        int u[7];
        int n, q;
        string req;
        q = half ? 8 : 16;
        if (kind == 0) begin u = '{2,2,8,4,4,0,0}; n = 5; req = "R7"; end
        else if (kind == 1) begin u = '{2,2,6,2,6,2,0}; n = 6; req = "R8"; end
        else begin u = '{2,2,6,2,4,2,2}; n = 7; req = "R8"; end
        check(liw_active == (kind == 0), req, "liw_active at pattern start",
              liw_active, kind == 0);
        for (int s = 0; s < n; s++) begin
            if (kind == 0 && s == 2)
                check(liw_sample == 1'b1, "R11", "liw_sample at long segment", liw_sample, 1);
            if (kind == 0 && s == 2) begin
                exp_seg(1'b1, 1, req);
                check(liw_sample == 1'b0, "R11", "liw_sample one cycle only", liw_sample, 0);
                exp_seg(1'b1, u[s]*q - 1, req);
            end else begin
                exp_seg(s % 2 == 0, u[s]*q, req);
            end
        end
    endtask

    task automatic exp_word(input logic [5:0] a, input bit zero, input string req);
        logic [44:0] f;
        logic [31:0] d;
        int hp;
        d  = mval(a);
        f  = '0;
        hp = half ? 16 : 32;
        check(mem_addr == a, "R1", "word address", mem_addr, a);
        if (!zero) begin
            for (int r = 0; r < 4; r++)
                for (int j = 0; j < 8; j++) begin
                    f[r*9+j] = d[r*8+j];
                    f[r*9+8] = f[r*9+8] ^ d[r*8+j];
                end
            for (int i = 0; i < 8; i++)
                for (int r = 0; r < 4; r++) f[36+i] = f[36+i] ^ d[r*8+i];
        end
        for (int b = 0; b < 45; b++) begin
            exp_seg(f[b], hp, req);
            exp_seg(!f[b], hp, req);
        end
    endtask

    task automatic exp_unit(input logic [5:0] a, input bit dbl, input bit zero, input string req);
        longint t0;
        if (dbl) exp_pat(0);
        t0 = cyc;
        exp_pat(0);
        exp_word(a, zero, req);
        check(cyc - t0 == (half ? 1600 : 3200), "R9", "window plus word cycles",
              cyc - t0, half ? 1600 : 3200);
    endtask

    task automatic do_reset(input logic [5:0] f, input logic [5:0] l, input bit h,
                            input bit lg, input logic [63:0] m);
        int w = 0;
        @(negedge clk);
        rst = 1'b1; first_a = f; last_a = l; half = h; login = lg; prot_mask = m;
        repeat (3) @(negedge clk);
        check(!mod_on && !liw_active && !liw_sample, "R13", "outputs quiet in reset",
              {mod_on, liw_active, liw_sample}, 0);
        rst = 1'b0;
        while (!liw_active && w < 10) begin @(negedge clk); w++; end
        check(liw_active == 1'b1, "R13", "listen window after reset", liw_active, 1);
    endtask

    task automatic t_range_full;
        do_reset(6'd3, 6'd5, 1'b0, 1'b0, '0);
        exp_unit(6'd3, 1'b1, 1'b0, "R4");
        exp_unit(6'd4, 1'b0, 1'b0, "R6");
        exp_unit(6'd5, 1'b0, 1'b0, "R3");
        exp_unit(6'd3, 1'b1, 1'b0, "R1");
    endtask

    task automatic t_single_half;
        do_reset(6'd7, 6'd7, 1'b1, 1'b0, '0);
        exp_unit(6'd7, 1'b1, 1'b0, "R6");
        exp_unit(6'd7, 1'b1, 1'b0, "R2");
    endtask

    task automatic t_protect;
        do_reset(6'd3, 6'd4, 1'b0, 1'b0, 64'h10);
        exp_unit(6'd3, 1'b1, 1'b0, "R5");
        exp_unit(6'd4, 1'b0, 1'b1, "R5");
        do_reset(6'd3, 6'd4, 1'b0, 1'b1, 64'h10);
        exp_unit(6'd3, 1'b1, 1'b0, "R5");
        exp_unit(6'd4, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_status;
        do_reset(6'd3, 6'd5, 1'b0, 1'b0, '0);
        exp_pat(0); exp_pat(0);
        ack_req = 1'b1;
        exp_word(6'd3, 1'b0, "R8");
        exp_pat(1);
        exp_pat(0);
        nak_req = 1'b1;
        exp_word(6'd4, 1'b0, "R8");
        exp_pat(2);
        exp_pat(0);
        ack_req = 1'b1; nak_req = 1'b1;
        exp_word(6'd5, 1'b0, "R8");
        exp_pat(2);
        exp_unit(6'd3, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_invalid;
        do_reset(6'd6, 6'd4, 1'b1, 1'b0, '0);
        exp_unit(6'd6, 1'b1, 1'b0, "R10");
        exp_unit(6'd6, 1'b1, 1'b0, "R10");
        do_reset(6'd5, 6'd34, 1'b1, 1'b0, '0);
        exp_unit(6'd5, 1'b1, 1'b0, "R10");
        exp_unit(6'd5, 1'b1, 1'b0, "R10");
    endtask

    task automatic t_id_words;
        do_reset(6'd32, 6'd33, 1'b1, 1'b0, '0);
        exp_unit(6'd32, 1'b1, 1'b0, "R1");
        exp_unit(6'd33, 1'b0, 1'b0, "R1");
        exp_unit(6'd32, 1'b1, 1'b0, "R1");
    endtask

    task automatic t_abort;
        do_reset(6'd3, 6'd3, 1'b0, 1'b0, '0);
        repeat (100) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(!mod_on && !liw_active, "R12", "parked right after abort",
              {mod_on, liw_active}, 0);
        exp_seg(1'b0, 500, "R12");
        check(!liw_active, "R12", "no listen window while parked", liw_active, 0);
    endtask

    initial begin
        #(8 * 190000);
        checks++; errors++;
        $display("FAIL watchdog: run hung actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_range_full();
        t_single_half();
        t_protect();
        t_status();
        t_invalid();
        t_id_words();
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule